// File: doc/BRIEF.md
# Dual-Pass ADC Conversion Sequencer

This block runs a single analog sample read against a 16-channel converter front end that is reached as two register banks of four byte addresses each. On a start strobe it takes a channel number, a two-bit range code and a single-ended flag, and packs them into a command byte. It then drives a simple byte bus to carry out the conversion: it writes the command, polls the ready flag, and reads the result.

The first result is always thrown away, because the input multiplexer needs one full conversion to settle after a channel change. The block therefore writes the same command a second time, polls again and keeps only the second result. For the two bipolar ranges it shifts the raw two's-complement reading into offset binary before returning it. If the converter never reports ready within a bounded number of polls, the read ends with an error flag and a zero sample, so the caller never hangs.

The bus is single-cycle: a read returns `bus_rdata` in the same cycle that `bus_rd` is high, and a write takes effect on the clock edge where `bus_wr` is high.

Top module: `adc_twopass_seq`

## Requirements
- R1: Channels 0 to 7 use bank 0 (`bus_addr[2]` = 0). Channels 8 to 15 use bank 1 (`bus_addr[2]` = 1), and their command is encoded from the channel number minus 8.
- R2: Command bit 7 is 1 for a single-ended measurement and 0 for a differential one. Command bit 6 is 1 when the channel number is odd.
- R3: Command bits 5:4 carry (channel / 2) mod 4. Bits 3:2 carry the range code. Bits 1:0 are zero.
- R4: `bus_addr[1:0]` selects the register inside a bank. The command is written at 2. Ready is bit 7 of the byte read at 3. The data low byte is read at 0, then the high byte at 1. A poll read directly follows every command write.
- R5: A successful read writes the same command twice. Each write is followed by polling and by reading both data bytes, and only the bytes read after the second write form the result.
- R6: For range codes 0 and 1, the sample is the raw 16-bit value plus 0x8000, wrapped modulo 2^16. For codes 2 and 3 it is the raw value.
- R7: After POLL_LIMIT consecutive status reads that all show ready clear, the block ends the read: it pulses `done` with `error` = 1 and `sample` = 0. Ready on the last permitted poll still succeeds. A successful read clears `error`.
- R8: `done` is a one-cycle pulse, and `busy` is low whenever `done` is high. After reset, `busy`, `done`, `error` and `sample` are all zero.
- R9: A start strobe while `busy` is high is ignored. The running read keeps its command and result, and no further conversion follows it.
- R10: While `busy` is low the block makes no bus read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a read (taken only when idle) |
| chan | input | 4 | Channel number 0 to 15 |
| range_code | input | 2 | Range code; 0 and 1 are bipolar |
| single_ended | input | 1 | 1 = single-ended, 0 = differential |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last read timed out |
| sample | output | 16 | Last result |
| bus_addr | output | 3 | Bank (bit 2) and register (bits 1:0) |
| bus_wr | output | 1 | Byte write strobe |
| bus_rd | output | 1 | Byte read strobe |
| bus_wdata | output | 8 | Write data (command byte) |
| bus_rdata | input | 8 | Read data, valid in the cycle of `bus_rd` |

## Verification
The bench builds the sequencer with POLL_LIMIT set to 12 instead of the default 100000. This makes the timeout cheap to reach, so the bench can check a ready that arrives on exactly the last allowed poll and one that arrives a single poll too late. The converter model can stall on either pass independently. This covers both a timeout before any data is read and a timeout after the discarded first result.

// File: rtl/adc_twopass_seq.sv
module adc_twopass_seq #(
  parameter int POLL_LIMIT = 100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  chan,
  input  logic [1:0]  range_code,
  input  logic        single_ended,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic [15:0] sample,
  output logic [2:0]  bus_addr,
  output logic        bus_wr,
  output logic        bus_rd,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata
);

  localparam int CW = $clog2(POLL_LIMIT + 1);
  localparam logic [CW-1:0] LAST_POLL = CW'(POLL_LIMIT - 1);
  localparam logic [1:0] OFS_LO = 2'd0, OFS_HI = 2'd1, OFS_CMD = 2'd2, OFS_STAT = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_POLL, S_LO, S_HI} state_t;

  state_t        st;
  logic [7:0]    cmd_q;
  logic          bank_q;
  logic          bipolar_q;
  logic          second;
  logic [CW-1:0] polls;
  logic [7:0]    lo_q;
  logic [1:0]    ofs;

  wire ready = bus_rdata[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cmd_q     <= '0;
      bank_q    <= 1'b0;
      bipolar_q <= 1'b0;
      second    <= 1'b0;
      polls     <= '0;
      lo_q      <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
      sample    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cmd_q     <= {single_ended, chan[0], chan[2:1], range_code, 2'b00};
          bank_q    <= chan[3];
          bipolar_q <= ~range_code[1];
          second    <= 1'b0;
          st        <= S_CMD;
        end
        S_CMD: begin
          polls <= '0;
          st    <= S_POLL;
        end
        S_POLL: begin
          if (ready) begin
            st <= S_LO;
          end else if (polls == LAST_POLL) begin
            done   <= 1'b1;
            error  <= 1'b1;
            sample <= '0;
            st     <= S_IDLE;
          end else begin
            polls <= polls + 1'b1;
          end
        end
        S_LO: begin
          lo_q <= bus_rdata;
          st   <= S_HI;
        end
        S_HI: begin
          if (!second) begin
            second <= 1'b1;
            st     <= S_CMD;
          end else begin
            sample <= {bus_rdata, lo_q} + (bipolar_q ? 16'h8000 : 16'h0000);
            error  <= 1'b0;
            done   <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_CMD:   ofs = OFS_CMD;
      S_POLL:  ofs = OFS_STAT;
      S_HI:    ofs = OFS_HI;
      default: ofs = OFS_LO;
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign bus_wr    = (st == S_CMD);
  assign bus_rd    = (st == S_POLL) || (st == S_LO) || (st == S_HI);
  assign bus_addr  = busy ? {bank_q, ofs} : 3'b000;
  assign bus_wdata = bus_wr ? cmd_q : 8'h00;

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r7_error_zero: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> sample == 16'h0000);
  a_r7_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    polls < CW'(POLL_LIMIT));
  a_r4_cmd_offset: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> bus_addr[1:0] == OFS_CMD);
  a_r4_poll_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> bus_rd && bus_addr[1:0] == OFS_STAT);
  a_r1_bank_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) && $past(bus_rd || bus_wr) |-> bus_addr[2] == $past(bus_addr[2]));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_wr && !bus_rd);
  a_r9_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> cmd_q == $past(cmd_q));

endmodule

// File: tb/test_adc_twopass_seq.sv
module test_adc_twopass_seq;
  localparam int L = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  chan = '0;
  logic [1:0]  range_code = '0;
  logic        single_ended = 1'b0;
  logic        busy, done, error;
  logic [15:0] sample;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  adc_twopass_seq #(.POLL_LIMIT(L)) i_adc_twopass_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan),
    .range_code(range_code), .single_ended(single_ended),
    .busy(busy), .done(done), .error(error), .sample(sample),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  // converter model
  logic [15:0] m_raw = '0;
  int m_d1 = 1, m_d2 = 1;
  int m_wr = 0, m_lo = 0, m_st = 0, m_cnt = 0;
  logic m_ready = 1'b0;
  logic [10:0] obs_q[$];
  int idle_viol = 0;

  wire [15:0] m_dat = (m_wr >= 2) ? m_raw : 16'hC3A5;
  assign bus_rdata = (bus_addr[1:0] == 2'd0) ? m_dat[7:0] :
                     (bus_addr[1:0] == 2'd1) ? m_dat[15:8] :
                     (bus_addr[1:0] == 2'd3) ? {m_ready, 7'h00} : 8'h00;

  always @(posedge clk) begin
    if (bus_wr) begin
      obs_q.push_back({bus_addr, bus_wdata});
      m_ready <= 1'b0;
      m_cnt   <= (m_wr == 0) ? m_d1 : m_d2;
      m_wr    <= m_wr + 1;
    end else if (m_cnt == 1) begin
      m_ready <= 1'b1;
      m_cnt   <= 0;
    end else if (m_cnt > 1) begin
      m_cnt <= m_cnt - 1;
    end
    if (bus_rd && bus_addr[1:0] == 2'd0) m_lo <= m_lo + 1;
    if (bus_rd && bus_addr[1:0] == 2'd3) m_st <= m_st + 1;
  end

  always @(negedge clk)
    if (rst_n && !busy && (bus_wr || bus_rd)) idle_viol++;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard: [15:0] sample, [16] error, [27:17] write word, [29:28] writes, [31:30] low reads
  logic [31:0] exp_q[$];
  bit exp_to1_q[$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected done", 1, 0);
      end else begin
        logic [31:0] e;
        bit to1;
        e = exp_q.pop_front();
        to1 = exp_to1_q.pop_front();
        chk(sample == e[15:0], "R6 sample", sample, e[15:0]);
        chk(error == e[16], "R7 error flag", error, e[16]);
        chk(obs_q.size() == int'(e[29:28]), "R5 command writes", obs_q.size(), e[29:28]);
        foreach (obs_q[k])
          chk(obs_q[k] == e[27:17], "R1 R2 R3 bank and command", obs_q[k], e[27:17]);
        chk(m_lo == int'(e[31:30]), "R5 low byte reads", m_lo, e[31:30]);
        if (to1) chk(m_st == L, "R7 poll count", m_st, L);
      end
    end
  end

  function automatic logic [7:0] ecmd(input int ch, input int rng, input bit se);
    logic [7:0] v;
    v = 8'h00;
    if (se) v |= 8'h80;
    if (ch % 2 == 1) v |= 8'h40;
    v |= 8'(((ch % 8) / 2) << 4);
    v |= 8'(rng << 2);
    return v;
  endfunction

  task automatic convert(input int ch, input int rng, input bit se, input logic [15:0] raw,
                         input int d1, input int d2, input bit glitch);
    bit to1, to2;
    logic [31:0] e;
    logic [15:0] s;
    to1 = (d1 == 0) || (d1 >= L);
    to2 = !to1 && ((d2 == 0) || (d2 >= L));
    s = (rng < 2) ? raw + 16'h8000 : raw;
    e = '0;
    e[15:0]  = (to1 || to2) ? 16'h0 : s;
    e[16]    = to1 || to2;
    e[27:17] = {(ch >= 8), 2'b10, ecmd(ch, rng, se)};
    e[29:28] = to1 ? 2'd1 : 2'd2;
    e[31:30] = to1 ? 2'd0 : (to2 ? 2'd1 : 2'd2);
    m_raw = raw; m_d1 = d1; m_d2 = d2;
    m_wr = 0; m_lo = 0; m_st = 0;
    obs_q.delete();
    exp_q.push_back(e);
    exp_to1_q.push_back(to1);
    @(negedge clk);
    start = 1'b1; chan = 4'(ch); range_code = 2'(rng); single_ended = se;
    @(negedge clk);
    start = 1'b0;
    if (glitch) begin
      repeat (3) @(negedge clk);
      start = 1'b1; chan = ~chan; range_code = ~range_code; single_ended = ~se;
      @(negedge clk);
      start = 1'b0;
    end
    do @(negedge clk); while (!done);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R8 reset busy/done", {busy, done}, 0);
    chk(error == 1'b0 && sample == 16'h0, "R8 reset error/sample", {error, sample}, 0);

    convert(3, 0, 1'b1, 16'h1234, 5, 5, 1'b0);   // R2 odd single-ended, bipolar
    convert(12, 2, 1'b0, 16'hFFFF, 3, 7, 1'b0);  // R1 bank 1, unipolar
    convert(15, 1, 1'b1, 16'h9000, 2, 1, 1'b0);  // R6 wrap
    convert(0, 3, 1'b0, 16'h0001, 1, 1, 1'b0);   // R3 range bits
    convert(8, 0, 1'b1, 16'h0000, 4, 4, 1'b0);   // R1 first channel of bank 1
    convert(6, 2, 1'b1, 16'hABCD, 0, 0, 1'b0);   // R7 first-pass timeout
    convert(5, 3, 1'b0, 16'h4321, L - 1, L - 1, 1'b0); // R7 ready on last poll
    convert(9, 1, 1'b0, 16'h7777, L, 2, 1'b0);   // R7 one poll too late
    convert(2, 0, 1'b1, 16'h2222, 3, 0, 1'b0);   // R7 second-pass timeout
    convert(10, 2, 1'b0, 16'h5A5A, 6, 6, 1'b1);  // R9 start while busy
    begin
      int w;
      w = m_wr;
      repeat (8) @(negedge clk);
      chk(busy == 1'b0, "R9 no extra conversion busy", busy, 0);
      chk(m_wr == w, "R9 no extra command write", m_wr, w);
    end
    chk(idle_viol == 0, "R10 bus idle while not busy", idle_viol, 0);
    chk(exp_q.size() == 0, "R8 every read completed", exp_q.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule